// File: doc/BRIEF.md
# SPI status flag and error controller

This block holds the status flags of an SPI peripheral and the logic that sets and clears them. It sits between a simple strobed register bus and a separate shift engine. The bus reaches three registers: control, status and data. The shift engine reports that it is busy, that a byte has finished, and which byte it received. The block watches the slave-select input and owns the peripheral-enable and master-select control bits. A mode fault forces those bits off, and the block then write-protects them until software runs the clearing sequence.

Four flags are kept: transfer done, mode fault, overrun and write collision. Each flag has its own clearing rule. The two-step rules use an armed bit. A status read that sees the flag set arms it, and the flag clears at the required second access. Accesses to other registers in between neither complete the sequence nor cancel it. The block also accepts or rejects data-register writes. An accepted write appears as a one-cycle load strobe towards the shift engine.

Register map. All reads are combinational in the strobe cycle. Reads of an unused address, and cycles without a read strobe, return zero.

| Address | Register | Bits |
|---------|----------|------|
| 0 | control | bit0 enable, bit1 master, bit2 interrupt enable |
| 1 | status | bit0 transfer done, bit1 mode fault, bit2 overrun, bit3 write collision |
| 2 | data | read: receive buffer; write: byte to transmit |

Top module: `spi_flag_ctrl`

## Requirements
- R1: When the master bit is 1 and `ss_in_n` is 0 at a clock edge, the mode-fault bit (status bit1) is 1 after that edge, and both the enable bit and the master bit are 0.
- R2: While the master bit is 0, the mode-fault bit never goes from 0 to 1, whatever `ss_in_n` does.
- R3: The mode-fault bit clears only when two steps have happened in order. First, a status read (address 1) sees it set. Later, a control write (address 0) arrives; other accesses in between are allowed. That completing write loads the enable bit (bit0) and the master bit (bit1) from the write data.
- R4: While mode fault is set and no status read has yet armed the clearing, a control write leaves enable and master at 0. The interrupt-enable bit (bit2) is still written.
- R5: When the engine reports a finished byte and transfer done (status bit0) is clear, or is being cleared in that cycle, transfer done becomes 1. The byte is stored, and data reads (address 2) return it.
- R6: When a byte finishes while transfer done is set and is not being cleared in that cycle, overrun (status bit2) becomes 1. The receive buffer keeps the earlier byte.
- R7: Any status read clears overrun, unless a new overrun is set in the same cycle.
- R8: A data write while `eng_busy` is 1 sets write collision (status bit3) and produces no `tx_load`. A data write while `eng_busy` is 0 gives a one-cycle `tx_load` with `tx_data` equal to the write data.
- R9: Write collision clears when a status read has seen it set and a data read then follows. A data write does not clear it.
- R10: Transfer done clears when a status read has seen it set and a data-register read or write then follows.
- R11: `irq` is interrupt enable AND (transfer done OR mode fault OR overrun). Write collision has no effect on `irq`.
- R12: After reset, all four flags are 0, enable, master and interrupt enable are 0, and the receive buffer reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| eng_busy | input | 1 | Shift engine is transferring a byte |
| eng_done | input | 1 | One-cycle pulse when a byte has finished |
| eng_rx | input | DATA_W | Byte received, valid with eng_done |
| ss_in_n | input | 1 | Slave-select input, active low |
| ctl_enable | output | 1 | Peripheral-enable control bit |
| ctl_master | output | 1 | Master-select control bit |
| tx_load | output | 1 | Accepted data-register write |
| tx_data | output | DATA_W | Byte to transmit, valid with tx_load |
| irq | output | 1 | Interrupt request |

## Verification
Most of the state in this block is a flag or an armed bit. A wrong value there shows at the ports on the next status read, since the flags are read back in the same strobe cycle. The three interrupting flags also show on `irq` in the cycle after their update. A wrong armed bit stays hidden until the second step of its sequence. It then shows as a flag that stays set, or one that clears too early, on the following status read. A lost override of the control bits shows on `ctl_enable` and `ctl_master` one cycle after the slave-select event or the control write.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_MS_BIT  = 1;
   localparam int unsigned CTRL_IE_BIT  = 2;
   localparam int unsigned STAT_TC_BIT  = 0;
   localparam int unsigned STAT_MF_BIT  = 1;
   localparam int unsigned STAT_OVR_BIT = 2;
   localparam int unsigned STAT_WC_BIT  = 3;
   localparam int unsigned FLAG_COUNT   = 4;

   typedef struct packed {
      logic wcol;
      logic ovr;
      logic mf;
      logic tc;
   } stat_t;

   typedef struct packed {
      logic ctrl_wr;
      logic stat_rd;
      logic data_rd;
      logic data_wr;
   } access_t;
endpackage

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
   import spi_flag_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  access_t           acc,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ss_in_n,
   output logic              en_q,
   output logic              ms_q,
   output logic              ie_q,
   output logic              mf_q
);
   logic mf_armed;
   logic fault_evt;
   logic clear_evt;
   logic wr_en;
   logic wr_ms;

   assign fault_evt = ms_q && !ss_in_n;
   assign clear_evt = mf_q && mf_armed && acc.ctrl_wr;
   assign wr_en     = wdata[CTRL_EN_BIT];
   assign wr_ms     = wdata[CTRL_MS_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ms_q     <= 1'b0;
         ie_q     <= 1'b0;
         mf_q     <= 1'b0;
         mf_armed <= 1'b0;
      end else begin
         if (acc.ctrl_wr)
            ie_q <= wdata[CTRL_IE_BIT];
         if (fault_evt) begin
            en_q <= 1'b0;
            ms_q <= 1'b0;
         end else if (acc.ctrl_wr) begin
            if (!mf_q || mf_armed) begin
               en_q <= wr_en;
               ms_q <= wr_ms;
            end else begin
               en_q <= en_q && wr_en;
               ms_q <= ms_q && wr_ms;
            end
         end
         if (fault_evt)
            mf_q <= 1'b1;
         else if (clear_evt)
            mf_q <= 1'b0;
         if (clear_evt || fault_evt)
            mf_armed <= 1'b0;
         else if (acc.stat_rd && mf_q)
            mf_armed <= 1'b1;
      end
   end

   assert_mf_forces_slave_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_q && !ss_in_n) |=> (mf_q && !en_q && !ms_q));

   assert_no_mf_in_slave_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ms_q && !mf_q) |=> !mf_q);

   assert_mf_clear_needs_sequence_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_q && !(mf_armed && acc.ctrl_wr)) |=> mf_q);

   assert_ctrl_bits_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_q && !mf_armed && acc.ctrl_wr) |=> (!en_q && !ms_q));
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
   import spi_flag_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  access_t           acc,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rx,
   output logic              tc_q,
   output logic              ovr_q,
   output logic [DATA_W-1:0] rxbuf_q
);
   logic tc_armed;
   logic tc_clear;
   logic tc_live;

   assign tc_clear = tc_q && tc_armed && (acc.data_rd || acc.data_wr);
   assign tc_live  = tc_q && !tc_clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tc_q     <= 1'b0;
         tc_armed <= 1'b0;
         ovr_q    <= 1'b0;
         rxbuf_q  <= '0;
      end else begin
         if (eng_done && !tc_live) begin
            tc_q    <= 1'b1;
            rxbuf_q <= eng_rx;
         end else if (tc_clear) begin
            tc_q <= 1'b0;
         end
         if (tc_clear)
            tc_armed <= 1'b0;
         else if (acc.stat_rd && tc_q)
            tc_armed <= 1'b1;
         if (eng_done && tc_live)
            ovr_q <= 1'b1;
         else if (acc.stat_rd)
            ovr_q <= 1'b0;
      end
   end

   assert_overrun_keeps_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && tc_q && !tc_clear) |=> (ovr_q && tc_q && $stable(rxbuf_q)));

   assert_done_captures_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && !tc_q) |=> (tc_q && rxbuf_q == $past(eng_rx)));

   assert_tc_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !tc_armed) |=> tc_q);
endmodule

// File: rtl/spi_wcol_flag.sv
module spi_wcol_flag
   import spi_flag_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  access_t acc,
   input  logic    eng_busy,
   output logic    wc_q,
   output logic    accept
);
   logic wc_armed;
   logic collide;
   logic wc_clear;

   assign collide  = acc.data_wr && eng_busy;
   assign accept   = acc.data_wr && !eng_busy;
   assign wc_clear = wc_q && wc_armed && acc.data_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wc_q     <= 1'b0;
         wc_armed <= 1'b0;
      end else begin
         if (collide)
            wc_q <= 1'b1;
         else if (wc_clear)
            wc_q <= 1'b0;
         if (wc_clear)
            wc_armed <= 1'b0;
         else if (acc.stat_rd && wc_q)
            wc_armed <= 1'b1;
      end
   end

   assert_collision_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.data_wr && eng_busy) |=> wc_q);

   assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wc_q && !(wc_armed && acc.data_rd)) |=> wc_q);

   assert_no_load_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !accept);
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
   import spi_flag_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1,
   parameter int unsigned DATA_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_rx,
   input  logic              ss_in_n,
   output logic              ctl_enable,
   output logic              ctl_master,
   output logic              tx_load,
   output logic [DATA_W-1:0] tx_data,
   output logic              irq
);
   localparam int unsigned NUM_REGS = 1 << ADDR_W;
   localparam int unsigned CTRL_W   = CTRL_IE_BIT + 1;

   if (DATA_W < FLAG_COUNT) begin : g_bad_data_w
      $error("spi_flag_ctrl: DATA_W must hold all status flags");
   end
   if (DATA_W < CTRL_W) begin : g_bad_ctrl_w
      $error("spi_flag_ctrl: DATA_W must hold all control bits");
   end
   if (CTRL_ADDR >= NUM_REGS || STAT_ADDR >= NUM_REGS || DATA_ADDR >= NUM_REGS) begin : g_bad_addr
      $error("spi_flag_ctrl: register address outside ADDR_W");
   end
   if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR == DATA_ADDR || STAT_ADDR == DATA_ADDR) begin : g_dup_addr
      $error("spi_flag_ctrl: register addresses must differ");
   end

   access_t           acc;
   stat_t             stat;
   logic              ie_q;
   logic [DATA_W-1:0] rxbuf;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] stat_word;

   assign acc.ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign acc.stat_rd = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
   assign acc.data_rd = bus_rd && (bus_addr == ADDR_W'(DATA_ADDR));
   assign acc.data_wr = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));

   spi_mode_ctrl #(.DATA_W(DATA_W)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (acc),
      .wdata   (bus_wdata),
      .ss_in_n (ss_in_n),
      .en_q    (ctl_enable),
      .ms_q    (ctl_master),
      .ie_q    (ie_q),
      .mf_q    (stat.mf)
   );

   spi_rx_flags #(.DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .eng_done (eng_done),
      .eng_rx   (eng_rx),
      .tc_q     (stat.tc),
      .ovr_q    (stat.ovr),
      .rxbuf_q  (rxbuf)
   );

   spi_wcol_flag u_wcol (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .eng_busy (eng_busy),
      .wc_q     (stat.wcol),
      .accept   (tx_load)
   );

   assign tx_data = bus_wdata;

   always_comb begin
      ctrl_word              = '0;
      ctrl_word[CTRL_EN_BIT] = ctl_enable;
      ctrl_word[CTRL_MS_BIT] = ctl_master;
      ctrl_word[CTRL_IE_BIT] = ie_q;
      stat_word               = '0;
      stat_word[STAT_TC_BIT]  = stat.tc;
      stat_word[STAT_MF_BIT]  = stat.mf;
      stat_word[STAT_OVR_BIT] = stat.ovr;
      stat_word[STAT_WC_BIT]  = stat.wcol;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_W'(CTRL_ADDR))
            bus_rdata = ctrl_word;
         else if (bus_addr == ADDR_W'(STAT_ADDR))
            bus_rdata = stat_word;
         else if (bus_addr == ADDR_W'(DATA_ADDR))
            bus_rdata = rxbuf;
      end
   end

   assign irq = ie_q && (stat.tc || stat.mf || stat.ovr);

   assert_wcol_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat.tc && !stat.mf && !stat.ovr) |-> !irq);
endmodule

// File: tb/sim_spi_flag_ctrl.sv
module sim_spi_flag_ctrl;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          eng_busy = 1'b0;
   logic          eng_done = 1'b0;
   logic [DW-1:0] eng_rx = '0;
   logic          ss_in_n = 1'b1;
   logic          ctl_enable, ctl_master, tx_load, irq;
   logic [DW-1:0] tx_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   spi_flag_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_rx(eng_rx), .ss_in_n(ss_in_n), .ctl_enable(ctl_enable), .ctl_master(ctl_master),
      .tx_load(tx_load), .tx_data(tx_data), .irq(irq)
   );

   // expected state, from the requirements
   bit m_en, m_ms, m_ie, m_tc, m_mf, m_ovr, m_wc, m_tca, m_mfa, m_wca;
   logic [DW-1:0] m_rx;

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] exp_rdata();
      if (!bus_rd) return '0;
      case (bus_addr)
         2'd0: return {5'b0, m_ie, m_ms, m_en};
         2'd1: return {4'b0, m_wc, m_ovr, m_mf, m_tc};
         2'd2: return m_rx;
         default: return '0;
      endcase
   endfunction

   function automatic bit exp_irq();
      return m_ie && (m_tc || m_mf || m_ovr);
   endfunction

   task automatic model_reset();
      {m_en, m_ms, m_ie, m_tc, m_mf, m_ovr, m_wc, m_tca, m_mfa, m_wca} = '0;
      m_rx = '0;
   endtask

   task automatic model_edge();
      bit st_rd, dr_rd, dr_wr, cr_wr, fault, mf_clr, tc_clr, tc_live, wset, wclr;
      st_rd  = bus_rd && bus_addr == 2'd1;
      dr_rd  = bus_rd && bus_addr == 2'd2;
      dr_wr  = bus_wr && bus_addr == 2'd2;
      cr_wr  = bus_wr && bus_addr == 2'd0;
      fault  = m_ms && !ss_in_n;
      mf_clr = m_mf && m_mfa && cr_wr;
      tc_clr = m_tc && m_tca && (dr_rd || dr_wr);
      tc_live = m_tc && !tc_clr;
      wset   = dr_wr && eng_busy;
      wclr   = m_wc && m_wca && dr_rd;
      if (cr_wr) m_ie = bus_wdata[2];
      if (fault) begin m_en = 0; m_ms = 0; end
      else if (cr_wr) begin
         if (!m_mf || m_mfa) begin m_en = bus_wdata[0]; m_ms = bus_wdata[1]; end
         else begin m_en = m_en && bus_wdata[0]; m_ms = m_ms && bus_wdata[1]; end
      end
      if (fault || mf_clr) m_mfa = 0; else if (st_rd && m_mf) m_mfa = 1;
      if (fault) m_mf = 1; else if (mf_clr) m_mf = 0;
      if (eng_done && tc_live) m_ovr = 1; else if (st_rd) m_ovr = 0;
      if (tc_clr) m_tca = 0; else if (st_rd && m_tc) m_tca = 1;
      if (eng_done && !tc_live) begin m_tc = 1; m_rx = eng_rx; end
      else if (tc_clr) m_tc = 0;
      if (wclr) m_wca = 0; else if (st_rd && m_wc) m_wca = 1;
      if (wset) m_wc = 1; else if (wclr) m_wc = 0;
   endtask

   // inputs are set after the falling edge; outputs compared 1 ns later
   task automatic step(input string tag);
      bit exp_load;
      #1;
      exp_load = bus_wr && bus_addr == 2'd2 && !eng_busy;
      check(bus_rdata === exp_rdata(), {tag, " rdata"}, bus_rdata, exp_rdata());
      check(irq === exp_irq(), "R11 irq", DW'(irq), DW'(exp_irq()));
      check(ctl_enable === m_en && ctl_master === m_ms, {tag, " ctl bits"},
            DW'({ctl_master, ctl_enable}), DW'({m_ms, m_en}));
      check(tx_load === exp_load, "R8 tx_load", DW'(tx_load), DW'(exp_load));
      if (exp_load) check(tx_data === bus_wdata, "R8 tx_data", tx_data, bus_wdata);
      @(posedge clk);
      if (rst_n) model_edge(); else model_reset();
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; eng_done = 0;
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      bus_addr = a; bus_rd = 1; step(tag);
   endtask
   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input string tag);
      bus_addr = a; bus_wr = 1; bus_wdata = d; step(tag);
   endtask
   task automatic peek(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
      bus_addr = a; bus_rd = 1; #1;
      check(bus_rdata === exp, tag, bus_rdata, exp);
      step(tag);
   endtask
   task automatic byte_done(input logic [DW-1:0] b, input string tag);
      eng_done = 1; eng_rx = b; step(tag);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk);
      step("R12"); step("R12");
      rst_n = 1;
      // R12: reset state
      peek(2'd0, 8'h00, "R12 ctrl after reset");
      peek(2'd1, 8'h00, "R12 status after reset");
      peek(2'd2, 8'h00, "R12 rxbuf after reset");

      // R2: slave with ss low sets nothing
      ss_in_n = 0; step("R2"); step("R2");
      peek(2'd1, 8'h00, "R2 no fault in slave mode");
      ss_in_n = 1;

      // R1: fault as master
      wr(2'd0, 8'h07, "R1"); peek(2'd0, 8'h07, "R1 ctrl set");
      ss_in_n = 0; step("R1"); ss_in_n = 1;
      check(!ctl_enable && !ctl_master, "R1 bits forced off", DW'({ctl_master, ctl_enable}), 8'h0);
      check(irq === 1'b1, "R11 irq on fault", DW'(irq), 8'h1);
      // R4: locked before arming
      wr(2'd0, 8'h03, "R4");
      peek(2'd0, 8'h00, "R4 write blocked, ie written");
      // R3: arm, unrelated access, then complete
      peek(2'd1, 8'h02, "R3 status shows fault");
      rd(2'd2, "R3"); wr(2'd2, 8'h11, "R3");
      peek(2'd1, 8'h02, "R3 still set before ctrl write");
      wr(2'd0, 8'h03, "R3");
      peek(2'd0, 8'h03, "R3 bits restored");
      peek(2'd1, 8'h00, "R3 fault cleared");
      wr(2'd0, 8'h04, "R3");

      // R5, R6, R7: receive path
      byte_done(8'hA5, "R5");
      peek(2'd2, 8'hA5, "R5 byte stored");
      byte_done(8'h3C, "R6");
      peek(2'd2, 8'hA5, "R6 buffer keeps first byte");
      peek(2'd1, 8'h05, "R6 overrun shown");
      peek(2'd1, 8'h01, "R7 overrun cleared by status read");
      // R10: tc cleared by data write after arming
      wr(2'd2, 8'h55, "R10");
      peek(2'd1, 8'h00, "R10 tc cleared by data write");
      check(irq === 1'b0, "R11 irq low", DW'(irq), 8'h0);

      // R8, R9: collision
      eng_busy = 1; wr(2'd2, 8'h99, "R8"); eng_busy = 0;
      peek(2'd1, 8'h08, "R8 collision flag");
      check(irq === 1'b0, "R11 wcol gives no irq", DW'(irq), 8'h0);
      wr(2'd2, 8'h42, "R9");
      peek(2'd1, 8'h08, "R9 data write does not clear");
      rd(2'd2, "R9");
      peek(2'd1, 8'h00, "R9 cleared by data read");

      // random phase against the model
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom;
         bus_addr  = 2'(r[1:0]);
         bus_rd    = (r[4:2] < 3);
         bus_wr    = (r[4:2] >= 3 && r[4:2] < 5);
         bus_wdata = DW'($urandom);
         eng_busy  = r[5];
         eng_done  = (r[8:6] == 0);
         eng_rx    = DW'($urandom);
         ss_in_n   = (r[12:9] != 0);
         step("R1 R5 R9 random");
      end

      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule